// File: doc/BRIEF.md
# Hashed Page-Directory Probe Unit

This unit runs when a translation lookaside buffer misses. It takes the address that missed, which has two parts: a 32-bit space identifier and a 32-bit offset. From these it forms the physical address of one slot in a hashed page directory and reads that slot with a single memory request. It then compares the tag of the returned entry against the address that missed.

When the tags match, the unit issues a one-cycle insert request. The fields in that request come directly from the entry, which is already laid out the way the TLB expects. In every other case the unit raises a one-cycle miss trap and keeps the faulting address on its outputs for the software handler. The unit never follows collision chains. A slot that holds a different translation goes to software in the same way as an empty slot.

The directory is physically contiguous, holds a power-of-two number of 16-byte entries, and is aligned to its own size. Its base and its index width are supplied as configuration inputs. A walk-enable input sends every miss to the trap path without any memory access.

Top module: `hpt_walker`

## Requirements
- R1: After reset, `busy`, `mem_req`, `ins_valid` and `trap_valid` are all low.
- R2: The slot index is `(miss_space[n-1:0] XOR vpn[n-1:0])`. Here `vpn` is `miss_offset[31:12]` and `n` is the effective index width.
- R3: `mem_addr` equals `cfg_base` with bits `[n+3:0]` cleared, ORed with the index shifted left by 4. Base bits below the table span therefore have no effect.
- R4: Each enabled walk makes exactly one read. `mem_req` rises in the second cycle after acceptance and stays high with `mem_addr` stable until the cycle in which `mem_ack` is sampled high. It then drops.
- R5: An entry counts as a hit when bit 127 (valid) is 1, bits [111:80] equal the space and bits [79:60] equal the vpn. A hit gives one `ins_valid` pulse carrying space [111:80], vpn [79:60], rights [59:52] and ppn [51:32] of that entry.
- R6: Any non-hit gives one `trap_valid` pulse. The link field in bits [31:0] is never used to start a second read.
- R7: `trap_space` and `trap_offset` equal the most recently accepted miss address. They hold that value until the next miss is accepted.
- R8: If `cfg_walk_en` is low when a miss is accepted, `trap_valid` pulses in the very next cycle and `mem_req` never rises.
- R9: A miss is accepted only while `busy` is low. `busy` is high from the cycle after acceptance through the pulse cycle, and low in the cycle after the pulse. A `miss_valid` seen during a walk, including during the pulse cycle, is ignored.
- R10: A `cfg_idx_bits` value above 16 is treated as 16.
- R11: `ins_valid` and `trap_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 32 | Physical base of the directory |
| cfg_idx_bits | input | 5 | log2 of the entry count (clamped to 16) |
| cfg_walk_en | input | 1 | 1 enables the probe, 0 traps every miss |
| miss_valid | input | 1 | A miss is offered |
| miss_space | input | 32 | Space identifier of the miss |
| miss_offset | input | 32 | Offset of the miss |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | 32 | Physical slot address |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 128 | Directory entry |
| ins_valid | output | 1 | One-cycle insert request |
| ins_space | output | 32 | Insert: space tag |
| ins_vpn | output | 20 | Insert: virtual page number |
| ins_rights | output | 8 | Insert: access rights |
| ins_ppn | output | 20 | Insert: physical page number |
| trap_valid | output | 1 | One-cycle miss trap |
| trap_space | output | 32 | Faulting space identifier |
| trap_offset | output | 32 | Faulting offset |

## Verification
Two things can fall on the same clock: the unit finishes a walk with an insert or trap pulse, and a new `miss_valid` arrives. The bench provokes this by raising `miss_valid` with a different address in the exact pulse cycle. It then requires `busy` to be low in the following cycle and the trap address to stay unchanged, which shows the offer was not accepted. A second case overlaps the read acknowledge with the cycle in which the request first appears (zero latency). In that case the bench checks that the request lasts exactly one cycle and that the walk still completes.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
   localparam int SPACE_W    = 32;
   localparam int OFF_W      = 32;
   localparam int PAGE_SHIFT = 12;
   localparam int VPN_W      = OFF_W - PAGE_SHIFT;
   localparam int PA_W       = 32;
   localparam int PPN_W      = PA_W - PAGE_SHIFT;
   localparam int RIGHTS_W   = 8;
   localparam int LINK_W     = 32;
   localparam int ENTRY_W    = 128;
   localparam int SLOT_SHIFT = 4;   // 16-byte entries
   localparam int PAD_W      = ENTRY_W - 1 - SPACE_W - VPN_W - RIGHTS_W - PPN_W - LINK_W;

   // Directory entry, bit 127 down to bit 0
   typedef struct packed {
      logic                valid;
      logic [PAD_W-1:0]    pad;
      logic [SPACE_W-1:0]  space;
      logic [VPN_W-1:0]    vpn;
      logic [RIGHTS_W-1:0] rights;
      logic [PPN_W-1:0]    ppn;
      logic [LINK_W-1:0]   link;
   } pde_t;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_HASH = 3'd1,
      ST_READ = 3'd2,
      ST_CMP  = 3'd3,
      ST_INS  = 3'd4,
      ST_TRAP = 3'd5
   } walk_st_t;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash import hpt_pkg::*; #(
   parameter int MAX_IDX_W = 16,
   parameter int IDXCFG_W  = $clog2(MAX_IDX_W + 1)
) (
   input  logic [MAX_IDX_W-1:0] space_lo,
   input  logic [MAX_IDX_W-1:0] vpn_lo,
   input  logic [PA_W-1:0]      base,
   input  logic [IDXCFG_W-1:0]  idx_bits,
   output logic [PA_W-1:0]      slot_addr
);
   localparam int SPAN_W = MAX_IDX_W + SLOT_SHIFT;
   localparam logic [IDXCFG_W-1:0] MAX_N = IDXCFG_W'(MAX_IDX_W);

   logic [IDXCFG_W-1:0]  n_eff;
   logic [MAX_IDX_W-1:0] idx_mask;
   logic [MAX_IDX_W-1:0] idx_val;
   logic [PA_W-1:0]      clr_mask;
   logic [PA_W-1:0]      idx_ext;

   // R10: oversize widths clamp to the largest supported table
   assign n_eff = (idx_bits > MAX_N) ? MAX_N : idx_bits;

   // Thermometer mask of the live index bits
   for (genvar i = 0; i < MAX_IDX_W; i++) begin : g_mask
      assign idx_mask[i] = (IDXCFG_W'(i) < n_eff);
   end

   // R2: space folded into the page number
   assign idx_val = (space_lo ^ vpn_lo) & idx_mask;

   if (PA_W > SPAN_W) begin : g_pad
      assign clr_mask = {{(PA_W-SPAN_W){1'b0}}, idx_mask, {SLOT_SHIFT{1'b1}}};
      assign idx_ext  = {{(PA_W-SPAN_W){1'b0}}, idx_val,  {SLOT_SHIFT{1'b0}}};
   end else begin : g_full
      assign clr_mask = {idx_mask, {SLOT_SHIFT{1'b1}}};
      assign idx_ext  = {idx_val,  {SLOT_SHIFT{1'b0}}};
   end

   // R3: aligned table, so the index replaces the low base bits
   assign slot_addr = (base & ~clr_mask) | idx_ext;
endmodule

// File: rtl/hpt_match.sv
module hpt_match import hpt_pkg::*; (
   input  pde_t                entry,
   input  logic [SPACE_W-1:0]  space,
   input  logic [VPN_W-1:0]    vpn,
   output logic                hit
);
   logic space_eq;
   logic vpn_eq;
   logic unused_fields;

   assign space_eq = (entry.space == space);
   assign vpn_eq   = (entry.vpn == vpn);
   // R5: valid plus full tag; R6: the chain link is not consulted
   assign hit      = entry.valid & space_eq & vpn_eq;
   assign unused_fields = ^{entry.pad, entry.link, entry.rights, entry.ppn};
endmodule

// File: rtl/hpt_ctrl.sv
module hpt_ctrl import hpt_pkg::*; (
   input  logic clk,
   input  logic rst_n,
   input  logic miss_valid,
   input  logic walk_en,
   input  logic mem_ack,
   input  logic hit,
   output logic accept,
   output logic load_slot,
   output logic load_pde,
   output logic busy,
   output logic mem_req,
   output logic ins_valid,
   output logic trap_valid
);
   walk_st_t st, st_nx;

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE: if (miss_valid) st_nx = walk_en ? ST_HASH : ST_TRAP;
         ST_HASH: st_nx = ST_READ;
         ST_READ: if (mem_ack) st_nx = ST_CMP;
         ST_CMP:  st_nx = hit ? ST_INS : ST_TRAP;
         ST_INS:  st_nx = ST_IDLE;
         ST_TRAP: st_nx = ST_IDLE;
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nx;
   end

   assign accept     = (st == ST_IDLE) && miss_valid;
   assign load_slot  = (st == ST_HASH);
   assign load_pde   = (st == ST_READ) && mem_ack;
   assign busy       = (st != ST_IDLE);
   assign mem_req    = (st == ST_READ);
   assign ins_valid  = (st == ST_INS);
   assign trap_valid = (st == ST_TRAP);

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && miss_valid) |=> busy);                                   // R9
   AST_PULSE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid || trap_valid) |=> (!busy && !ins_valid && !trap_valid)); // R9
   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ins_valid && trap_valid));                                      // R11
   AST_NOWALK_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && miss_valid && !walk_en) |=> (trap_valid && !mem_req));  // R8
   AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack) |=> !mem_req);                               // R4
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker import hpt_pkg::*; #(
   parameter int MAX_IDX_W = 16,
   parameter int IDXCFG_W  = $clog2(MAX_IDX_W + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PA_W-1:0]     cfg_base,
   input  logic [IDXCFG_W-1:0] cfg_idx_bits,
   input  logic                cfg_walk_en,
   input  logic                miss_valid,
   input  logic [SPACE_W-1:0]  miss_space,
   input  logic [OFF_W-1:0]    miss_offset,
   output logic                busy,
   output logic                mem_req,
   output logic [PA_W-1:0]     mem_addr,
   input  logic                mem_ack,
   input  logic [ENTRY_W-1:0]  mem_rdata,
   output logic                ins_valid,
   output logic [SPACE_W-1:0]  ins_space,
   output logic [VPN_W-1:0]    ins_vpn,
   output logic [RIGHTS_W-1:0] ins_rights,
   output logic [PPN_W-1:0]    ins_ppn,
   output logic                trap_valid,
   output logic [SPACE_W-1:0]  trap_space,
   output logic [OFF_W-1:0]    trap_offset
);
   // Elaboration-time parameter checks
   if (MAX_IDX_W < 1) begin : g_chk_min
      $error("hpt_walker: MAX_IDX_W must be at least 1");
   end
   if (MAX_IDX_W > VPN_W || MAX_IDX_W > SPACE_W) begin : g_chk_fold
      $error("hpt_walker: index wider than the hashed fields");
   end
   if (MAX_IDX_W + SLOT_SHIFT > PA_W) begin : g_chk_span
      $error("hpt_walker: table span exceeds the physical address");
   end
   if (PAD_W < 0) begin : g_chk_entry
      $error("hpt_walker: entry fields do not fit the entry width");
   end

   logic              accept, load_slot, load_pde, hit;
   logic [SPACE_W-1:0] req_space;
   logic [OFF_W-1:0]   req_off;
   logic [VPN_W-1:0]   req_vpn;
   logic [PA_W-1:0]    slot_addr, slot_q;
   pde_t               pde_q;

   assign req_vpn = req_off[OFF_W-1:PAGE_SHIFT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_space <= '0;
         req_off   <= '0;
         slot_q    <= '0;
         pde_q     <= '0;
      end else begin
         if (accept) begin
            req_space <= miss_space;
            req_off   <= miss_offset;
         end
         if (load_slot) slot_q <= slot_addr;
         if (load_pde)  pde_q  <= pde_t'(mem_rdata);
      end
   end

   hpt_hash #(.MAX_IDX_W(MAX_IDX_W), .IDXCFG_W(IDXCFG_W)) u_hash (
      .space_lo  (req_space[MAX_IDX_W-1:0]),
      .vpn_lo    (req_vpn[MAX_IDX_W-1:0]),
      .base      (cfg_base),
      .idx_bits  (cfg_idx_bits),
      .slot_addr (slot_addr)
   );

   hpt_match u_match (
      .entry (pde_q),
      .space (req_space),
      .vpn   (req_vpn),
      .hit   (hit)
   );

   hpt_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .miss_valid (miss_valid),
      .walk_en    (cfg_walk_en),
      .mem_ack    (mem_ack),
      .hit        (hit),
      .accept     (accept),
      .load_slot  (load_slot),
      .load_pde   (load_pde),
      .busy       (busy),
      .mem_req    (mem_req),
      .ins_valid  (ins_valid),
      .trap_valid (trap_valid)
   );

   assign mem_addr    = slot_q;
   // R5: entry fields pass to the TLB unchanged
   assign ins_space   = pde_q.space;
   assign ins_vpn     = pde_q.vpn;
   assign ins_rights  = pde_q.rights;
   assign ins_ppn     = pde_q.ppn;
   assign trap_space  = req_space;
   assign trap_offset = req_off;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));        // R4
   AST_TRAP_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy || !miss_valid) |=> ($stable(trap_space) && $stable(trap_offset))); // R7
   AST_SLOT_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[SLOT_SHIFT-1:0] == '0));                    // R3
endmodule

// File: tb/hpt_walker_test.sv
module hpt_walker_test;
   import hpt_pkg::*;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic         rst_n;
   logic [31:0]  cfg_base;
   logic [4:0]   cfg_idx_bits;
   logic         cfg_walk_en;
   logic         miss_valid;
   logic [31:0]  miss_space, miss_offset;
   logic         busy, mem_req, mem_ack;
   logic [31:0]  mem_addr;
   logic [127:0] mem_rdata;
   logic         ins_valid, trap_valid;
   logic [31:0]  ins_space, trap_space, trap_offset;
   logic [19:0]  ins_vpn, ins_ppn;
   logic [7:0]   ins_rights;

   hpt_walker uut (
      .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_idx_bits(cfg_idx_bits),
      .cfg_walk_en(cfg_walk_en), .miss_valid(miss_valid), .miss_space(miss_space),
      .miss_offset(miss_offset), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .ins_valid(ins_valid),
      .ins_space(ins_space), .ins_vpn(ins_vpn), .ins_rights(ins_rights),
      .ins_ppn(ins_ppn), .trap_valid(trap_valid), .trap_space(trap_space),
      .trap_offset(trap_offset)
   );

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;

   task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_addr(input logic [31:0] base, input logic [31:0] sp,
                                            input logic [31:0] off, input int nb);
      int          n;
      logic [31:0] m, idx;
      n   = (nb > 16) ? 16 : nb;
      m   = (32'd1 << n) - 32'd1;
      idx = (sp ^ (off >> 12)) & m;
      return (base & ~((m << 4) | 32'hF)) | (idx << 4);
   endfunction

   function automatic logic [127:0] mk_entry(input bit v, input logic [31:0] sp, input logic [19:0] vpn,
                                             input logic [7:0] rt, input logic [19:0] ppn, input logic [31:0] lnk);
      return {v, 15'd0, sp, vpn, rt, ppn, lnk};
   endfunction

   task automatic walk(input logic [31:0] base, input int nb, input bit wen,
                       input logic [31:0] sp, input logic [31:0] off, input logic [127:0] ent,
                       input int lat, input bit intrude, input bit collide);
      int   reqs, lat_cnt, pulse_at;
      bit   got_ins, got_trap, addr_ok, acked, extra_req, busy_gap, exp_hit;
      logic [31:0] seen_addr;
      logic [31:0] c_isp; logic [19:0] c_ivpn, c_ippn; logic [7:0] c_irt;
      logic [31:0] c_tsp, c_toff;
      reqs = 0; lat_cnt = 0; pulse_at = -1; got_ins = 0; got_trap = 0; addr_ok = 1;
      acked = 0; extra_req = 0; busy_gap = 0; seen_addr = '0;
      c_isp = '0; c_ivpn = '0; c_ippn = '0; c_irt = '0; c_tsp = '0; c_toff = '0;
      exp_hit = wen && ent[127] && (ent[111:80] == sp) && (ent[79:60] == off[31:12]);

      @(negedge clk);
      while (busy) @(negedge clk);
      cfg_base = base; cfg_idx_bits = 5'(nb); cfg_walk_en = wen;
      miss_space = sp; miss_offset = off; miss_valid = 1'b1;
      @(negedge clk);
      miss_valid = 1'b0;
      for (int c = 0; c < 64; c++) begin
         mem_ack = 1'b0;
         mem_rdata = {$urandom, $urandom, $urandom, $urandom};
         if (intrude && c == 1) begin
            miss_valid = 1'b1; miss_space = ~sp; miss_offset = ~off;
         end else if (intrude && c == 2) begin
            miss_valid = 1'b0;
         end
         if (ins_valid || trap_valid) begin
            got_ins = ins_valid; got_trap = trap_valid; pulse_at = c;
            c_isp = ins_space; c_ivpn = ins_vpn; c_ippn = ins_ppn; c_irt = ins_rights;
            c_tsp = trap_space; c_toff = trap_offset;
            break;
         end
         if (!busy) busy_gap = 1;
         if (mem_req) begin
            if (acked) extra_req = 1;
            if (reqs == 0) seen_addr = mem_addr;
            else if (mem_addr !== seen_addr) addr_ok = 0;
            reqs++;
            if (lat_cnt == lat) begin
               mem_ack = 1'b1; mem_rdata = ent; acked = 1;
            end else lat_cnt++;
         end
         @(negedge clk);
      end
      mem_ack = 1'b0;

      check(pulse_at >= 0, "R9 walk completes", 128'(pulse_at), 128'd1);
      check(!busy_gap, "R9 busy held until pulse", 128'(busy_gap), 128'd0);
      check(!(got_ins && got_trap), "R11 exclusive pulses", {got_ins, got_trap}, 128'd0);
      if (wen) begin
         check(reqs == lat + 1, "R4 request length", 128'(reqs), 128'(lat + 1));
         check(addr_ok && !extra_req, "R4 stable single read", {addr_ok, extra_req}, 128'd2);
         check(seen_addr === exp_addr(base, sp, off, nb), "R2/R3 slot address",
               seen_addr, exp_addr(base, sp, off, nb));
      end else begin
         check(reqs == 0, "R8 no read when disabled", 128'(reqs), 128'd0);
         check(pulse_at == 0, "R8 immediate trap", 128'(pulse_at), 128'd0);
      end
      if (exp_hit) begin
         check(got_ins, "R5 insert on hit", 128'(got_ins), 128'd1);
         check({c_isp, c_ivpn, c_irt, c_ippn} === ent[111:32], "R5 insert fields",
               {c_isp, c_ivpn, c_irt, c_ippn}, ent[111:32]);
      end else begin
         check(got_trap && !got_ins, "R6 trap on non-hit", {got_ins, got_trap}, 128'd1);
      end
      check({c_tsp, c_toff} === {sp, off}, "R7 trap address", {c_tsp, c_toff}, {sp, off});

      // Pulse cycle: optionally offer a new miss that must be ignored
      if (collide) begin
         miss_valid = 1'b1; miss_space = sp ^ 32'h5A5A_0001; miss_offset = off ^ 32'h0000_3000;
      end
      @(negedge clk);
      miss_valid = 1'b0;
      check(!busy && !ins_valid && !trap_valid, "R9 idle after pulse",
            {busy, ins_valid, trap_valid}, 128'd0);
      if (collide) begin
         repeat (3) @(negedge clk);
         check(!busy && {trap_space, trap_offset} === {sp, off}, "R9/R7 pulse-cycle offer ignored",
               {busy, trap_space, trap_offset}, {1'b0, sp, off});
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL R9 watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] sp, off, base;
      logic [127:0] ent;
      void'($urandom(32'd4242));
      rst_n = 1'b0; cfg_base = '0; cfg_idx_bits = '0; cfg_walk_en = 1'b1;
      miss_valid = 1'b0; miss_space = '0; miss_offset = '0; mem_ack = 1'b0; mem_rdata = '0;
      repeat (3) @(negedge clk);
      check({busy, mem_req, ins_valid, trap_valid} == 4'b0, "R1 reset outputs",
            {busy, mem_req, ins_valid, trap_valid}, 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check({busy, mem_req, ins_valid, trap_valid} == 4'b0, "R1 idle after reset",
            {busy, mem_req, ins_valid, trap_valid}, 128'd0);

      // Directed: hit, zero latency (ack together with first request cycle)
      sp = 32'h0000_1234; off = 32'h0ABC_D123;
      walk(32'h8000_0000, 10, 1, sp, off, mk_entry(1, sp, off[31:12], 8'h3C, 20'hF00D5, 32'h0), 0, 0, 0);
      // R6: invalid entry with a non-zero link
      walk(32'h8000_0000, 10, 1, sp, off, mk_entry(0, sp, off[31:12], 8'h1, 20'h1, 32'h9000_0040), 2, 0, 0);
      // R6: space and vpn mismatches
      walk(32'h8000_0000, 12, 1, sp, off, mk_entry(1, sp ^ 32'h8000_0000, off[31:12], 8'h1, 20'h2, 32'h0), 1, 0, 0);
      walk(32'h8000_0000, 12, 1, sp, off, mk_entry(1, sp, off[31:12] ^ 20'h80000, 8'h1, 20'h2, 32'h0), 1, 0, 0);
      // R8: disabled walk traps even on a matching entry
      walk(32'h8000_0000, 12, 0, sp, off, mk_entry(1, sp, off[31:12], 8'h1, 20'h2, 32'h0), 0, 0, 0);
      // R10: clamp of oversize width, and zero width
      walk(32'h4000_0000, 31, 1, 32'hFFFF_FFFF, 32'h1234_5000, mk_entry(1, 32'hFFFF_FFFF, 20'h12345, 8'h7, 20'h3, 32'h0), 0, 0, 0);
      walk(32'h4000_0000, 0, 1, 32'hFFFF_FFFF, 32'h1234_5000, mk_entry(1, 32'hFFFF_FFFF, 20'h12345, 8'h7, 20'h3, 32'h0), 0, 0, 0);
      // R3: misaligned base bits inside the span are dropped
      walk(32'h1234_5678, 8, 1, 32'h55, 32'h000A_A000, mk_entry(1, 32'h55, 20'h000AA, 8'h9, 20'h4, 32'h0), 3, 0, 0);
      // R9: offers during a walk and in the pulse cycle are ignored
      walk(32'h2000_0000, 6, 1, sp, off, mk_entry(1, sp, off[31:12], 8'h2, 20'h5, 32'h0), 2, 1, 1);
      walk(32'h2000_0000, 6, 0, sp, off, '0, 0, 0, 1);

      // Random walks
      for (int k = 0; k < 200; k++) begin
         sp   = $urandom;
         off  = $urandom;
         base = $urandom;
         ent  = mk_entry(1, sp, off[31:12], 8'($urandom), 20'($urandom), $urandom);
         if ($urandom_range(0, 1) == 0) begin
            int b;
            b = $urandom_range(60, 112);
            if (b == 112) ent[127] = 1'b0; else ent[b] = ~ent[b];
         end
         walk(base, $urandom_range(0, 20), ($urandom_range(0, 7) != 0), sp, off, ent,
              $urandom_range(0, 4), ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0));
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule